// File: doc/BRIEF.md
# SDRAM Read-Latency and Data-Mask Datapath

This block sits on the controller side of a synchronous DRAM data bus and aligns the data path with the command stream. It counts out each read or write burst from its command strobe and the programmed burst length. For writes, it puts the write data and its mask on the pins in the same clock as each beat. For reads, it waits out the programmed read latency, captures the returning bus data and reports each beat with a valid flag.

The mask pin has two timings. During writes it acts in the same clock as the beat. During reads it blanks the bus beat two clocks after the mask was raised, whatever read latency is programmed. The block also drives the bus output enable, and it releases that enable one clock before read data is due so that the bus can turn around without contention. A burst may be cut short by a stop strobe, or replaced by a new read or write command in any cycle.

Top module: `sdr_lat_mask_dp`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises with all strobes low, rd_valid_o, rd_drop_o, rd_data_o and dq_oe_o are all zero.
- R2: The read latency L equals lat_i for values 1 to 3, and lat_i = 0 also selects L = 1. A read beat issued in cycle t is sampled from dq_i at the end of cycle t+L and is reported on rd_data_o in cycle t+L+1.
- R3: bl_i selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. The first beat falls in the command cycle and the remaining beats fall in the cycles that follow.
- R4: In a write beat cycle where dq_oe_o is high, dq_o equals wr_data_i in that same cycle. Whenever dq_oe_o is low, dq_o is zero.
- R5: dqm_o equals mask_i in the same cycle, so a write-beat mask takes effect with zero delay.
- R6: A read beat on the bus in cycle b is reported with rd_valid_o high only if mask_i was low in cycle b-2. Otherwise it is reported with rd_drop_o high, rd_valid_o low and rd_data_o zero.
- R7: When term_i is high without a command, it cancels the current burst's beats from that cycle on. Read beats issued before term_i still return. If a command arrives in the same cycle, the command wins over term_i.
- R8: A read or write command is accepted in any cycle and replaces any burst in progress. If rd_cmd_i and wr_cmd_i are both high, the command is treated as a read.
- R9: dq_oe_o is high only in a write beat cycle where no read data is due on the bus in that cycle or in the next cycle.
- R10: In every cycle where rd_valid_o is low, rd_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_cmd_i | input | 1 | Read command strobe |
| wr_cmd_i | input | 1 | Write command strobe |
| term_i | input | 1 | Burst stop or precharge strobe |
| lat_i | input | 2 | Read latency, 0 or 1 gives 1 clock, 2 and 3 give 2 and 3 clocks |
| bl_i | input | 2 | Burst length code, where n gives 2^n beats |
| mask_i | input | 1 | Per-beat data mask from the command side |
| wr_data_i | input | DW | Write data for the current beat |
| dq_i | input | DW | Data sampled from the bus pins |
| dq_o | output | DW | Data driven to the bus pins |
| dq_oe_o | output | 1 | Bus output enable |
| dqm_o | output | 1 | Mask pin |
| rd_data_o | output | DW | Captured read beat |
| rd_valid_o | output | 1 | Captured read beat is valid |
| rd_drop_o | output | 1 | A read beat returned but was masked |

## Verification
The hardest case to reach is a read mask whose two-clock delay differs from the read latency in force. In that case the mask blanks a beat other than the one issued alongside it. Reaching it takes latency 3 with an 8-beat burst and mask pulses placed off the command cycle, and then latency 1 with a mask raised before the read command. The turnaround guard also needs a write that interrupts a read still in flight, so that the write beats fall in the cycles where read data is due or about to be due. Separately, a stop strobe must arrive together with a write command.

// File: rtl/sdr_dp_pkg.sv
package sdr_dp_pkg;
  // Burst length code width; the longest burst is 2^(2^BL_CODE_W - 1) beats.
  localparam int unsigned BL_CODE_W = 2;
  localparam int unsigned BEAT_CNT_W = (1 << BL_CODE_W) - 1;

  typedef enum logic [1:0] {
    LAT_DFLT = 2'd0,
    LAT_ONE  = 2'd1,
    LAT_TWO  = 2'd2,
    LAT_THR  = 2'd3
  } rd_lat_e;

  function automatic logic [BEAT_CNT_W-1:0] beats_left(input logic [BL_CODE_W-1:0] code);
    logic [BEAT_CNT_W-1:0] one;
    one = BEAT_CNT_W'(1);
    return (one << code) - one;
  endfunction
endpackage

// File: rtl/sdr_burst_track.sv
module sdr_burst_track
  import sdr_dp_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_cmd_i,
  input  logic                 wr_cmd_i,
  input  logic                 term_i,
  input  logic [BL_CODE_W-1:0] bl_i,
  output logic                 rd_beat_o,
  output logic                 wr_beat_o
);
  logic [BEAT_CNT_W-1:0] rem_q;
  logic                  kind_rd_q;
  logic                  cmd, busy, beat, is_rd;

  assign cmd   = rd_cmd_i | wr_cmd_i;
  assign busy  = (rem_q != '0);
  assign beat  = cmd | (busy & ~term_i);
  assign is_rd = cmd ? rd_cmd_i : kind_rd_q;  // read wins on collision

  assign rd_beat_o = beat & is_rd;
  assign wr_beat_o = beat & ~is_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q     <= '0;
      kind_rd_q <= 1'b0;
    end else if (cmd) begin
      rem_q     <= beats_left(bl_i);
      kind_rd_q <= rd_cmd_i;
    end else if (term_i) begin
      rem_q <= '0;
    end else if (busy) begin
      rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int unsigned DW       = 4,
  parameter int unsigned MAX_LAT  = 3,
  parameter int unsigned MASK_DLY = 2,
  parameter int unsigned LAT_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_beat_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             mask_i,
  input  logic [DW-1:0]    dq_i,
  output logic             due_now_o,
  output logic             due_next_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_valid_o,
  output logic             rd_drop_o
);
  logic [MAX_LAT-1:0]  vld_sr;
  logic [MASK_DLY-1:0] msk_sr;
  logic [LAT_W-1:0]    lat_eff;
  logic                masked;

  always_comb begin
    lat_eff = lat_i;
    if (lat_i == '0)                 lat_eff = LAT_W'(1);
    else if (int'(lat_i) > MAX_LAT)  lat_eff = LAT_W'(MAX_LAT);
  end

  // Tap selects how many clocks a read beat waits before the bus carries it.
  assign due_now_o  = vld_sr[lat_eff - LAT_W'(1)];
  assign due_next_o = (lat_eff == LAT_W'(1)) ? rd_beat_i : vld_sr[lat_eff - LAT_W'(2)];
  assign masked     = msk_sr[MASK_DLY-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_sr <= '0;
    else         vld_sr <= {vld_sr[MAX_LAT-2:0], rd_beat_i};
  end

  generate
    if (MASK_DLY > 1) begin : g_msk_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) msk_sr <= '0;
        else         msk_sr <= {msk_sr[MASK_DLY-2:0], mask_i};
      end
    end else begin : g_msk_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) msk_sr <= '0;
        else         msk_sr <= mask_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_drop_o  <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= due_now_o & ~masked;
      rd_drop_o  <= due_now_o & masked;
      rd_data_o  <= (due_now_o & ~masked) ? dq_i : '0;
    end
  end
endmodule

// File: rtl/sdr_lat_mask_dp.sv
module sdr_lat_mask_dp
  import sdr_dp_pkg::*;
#(
  parameter int unsigned DW          = 4,
  parameter int unsigned MAX_LAT     = 3,
  parameter int unsigned RD_MASK_DLY = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_cmd_i,
  input  logic          wr_cmd_i,
  input  logic          term_i,
  input  logic [1:0]    lat_i,
  input  logic [1:0]    bl_i,
  input  logic          mask_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          dqm_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          rd_drop_o
);
  localparam int unsigned LAT_W = 2;

  logic rd_beat, wr_beat;
  logic due_now, due_next;

  sdr_burst_track u_burst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_cmd_i  (rd_cmd_i),
    .wr_cmd_i  (wr_cmd_i),
    .term_i    (term_i),
    .bl_i      (bl_i),
    .rd_beat_o (rd_beat),
    .wr_beat_o (wr_beat)
  );

  sdr_rd_pipe #(
    .DW       (DW),
    .MAX_LAT  (MAX_LAT),
    .MASK_DLY (RD_MASK_DLY),
    .LAT_W    (LAT_W)
  ) u_rd_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_beat_i  (rd_beat),
    .lat_i      (lat_i),
    .mask_i     (mask_i),
    .dq_i       (dq_i),
    .due_now_o  (due_now),
    .due_next_o (due_next),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .rd_drop_o  (rd_drop_o)
  );

  // Release the bus a clock ahead of returning read data.
  assign dq_oe_o = wr_beat & ~due_now & ~due_next;
  assign dq_o    = dq_oe_o ? wr_data_i : '0;
  assign dqm_o   = mask_i;
endmodule

// File: rtl/sdr_lat_mask_dp_chk.sv
module sdr_lat_mask_dp_chk #(
  parameter int unsigned DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_cmd_i,
  input logic          wr_cmd_i,
  input logic          term_i,
  input logic          mask_i,
  input logic          due_now,
  input logic [DW-1:0] dq_o,
  input logic          dq_oe_o,
  input logic [DW-1:0] rd_data_o,
  input logic          rd_valid_o,
  input logic          rd_drop_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  AST_OE_CLEAR_OF_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !due_now);  // R9
  AST_VALID_DROP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && rd_drop_o));  // R6
  AST_MASK_BLANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && rd_valid_o) |-> !$past(mask_i, 3));  // R6
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (rd_data_o == '0));  // R10
  AST_BUS_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == '0));  // R4
  AST_READ_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd_i |-> !dq_oe_o);  // R8
  AST_TERM_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !rd_cmd_i && !wr_cmd_i) |-> !dq_oe_o);  // R7
endmodule

bind sdr_lat_mask_dp sdr_lat_mask_dp_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_cmd_i   (rd_cmd_i),
  .wr_cmd_i   (wr_cmd_i),
  .term_i     (term_i),
  .mask_i     (mask_i),
  .due_now    (due_now),
  .dq_o       (dq_o),
  .dq_oe_o    (dq_oe_o),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .rd_drop_o  (rd_drop_o)
);

// File: tb/tb_sdr_lat_mask_dp.sv
module tb_sdr_lat_mask_dp;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;
  localparam int NC = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_cmd_i = 0, wr_cmd_i = 0, term_i = 0, mask_i = 0;
  logic [1:0] lat_i = 2'd2, bl_i = 2'd0;
  logic [DW-1:0] wr_data_i = '0, dq_i = '0;
  logic [DW-1:0] dq_o, rd_data_o;
  logic dq_oe_o, dqm_o, rd_valid_o, rd_drop_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic s_rd[NC], s_wr[NC], s_term[NC], s_mask[NC];
  logic e_rd[NC], e_wr[NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_lat_mask_dp dut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_cmd_i(rd_cmd_i), .wr_cmd_i(wr_cmd_i),
    .term_i(term_i), .lat_i(lat_i), .bl_i(bl_i), .mask_i(mask_i),
    .wr_data_i(wr_data_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .dqm_o(dqm_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .rd_drop_o(rd_drop_o)
  );

  function automatic logic [DW-1:0] wval(input int c);
    return DW'(c * 3 + 1);
  endfunction
  function automatic logic [DW-1:0] bval(input int c);
    return DW'(c + 5) ^ DW'(12);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < NC; i++) begin
      s_rd[i] = 0; s_wr[i] = 0; s_term[i] = 0; s_mask[i] = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_cmd_i = 0; wr_cmd_i = 0; term_i = 0; mask_i = 0;
    end
  endtask

  // Beat schedule per R3, R7 and R8.
  task automatic model_beats(input logic [1:0] bl);
    int rem = 0;
    logic kind = 0;
    for (int c = 0; c < NC; c++) begin
      e_rd[c] = 0; e_wr[c] = 0;
      if (s_rd[c] || s_wr[c]) begin
        rem = (1 << bl) - 1; kind = s_rd[c];
        e_rd[c] = s_rd[c]; e_wr[c] = !s_rd[c];
      end else if (s_term[c]) begin
        rem = 0;
      end else if (rem > 0) begin
        rem--; e_rd[c] = kind; e_wr[c] = !kind;
      end
    end
  endtask

  function automatic logic due(input int b, input int lat);
    if (b < lat || b >= NC) return 1'b0;
    return e_rd[b - lat];
  endfunction

  task automatic run_seq(input logic [1:0] lat, input logic [1:0] bl, input string name);
    int L = (lat == 0) ? 1 : int'(lat);
    logic exp_oe, exp_v, exp_d, m;
    idle(5);
    lat_i = lat; bl_i = bl;
    model_beats(bl);
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      rd_cmd_i = s_rd[c]; wr_cmd_i = s_wr[c]; term_i = s_term[c]; mask_i = s_mask[c];
      wr_data_i = wval(c); dq_i = bval(c);
      #1;
      exp_oe = e_wr[c] && !due(c, L) && !due(c + 1, L);
      m = (c >= 3) ? s_mask[c-3] : 1'b0;
      exp_d = (c >= 1) ? due(c - 1, L) : 1'b0;
      exp_v = exp_d && !m;
      chk($sformatf("R9 R3 R7 R8 oe %s c=%0d", name, c), 32'(dq_oe_o), 32'(exp_oe));
      chk($sformatf("R4 dq %s c=%0d", name, c), 32'(dq_o), exp_oe ? 32'(wval(c)) : 32'd0);
      chk($sformatf("R5 dqm %s c=%0d", name, c), 32'(dqm_o), 32'(s_mask[c]));
      chk($sformatf("R2 R6 valid %s c=%0d", name, c), 32'(rd_valid_o), 32'(exp_v));
      chk($sformatf("R6 drop %s c=%0d", name, c), 32'(rd_drop_o), 32'(exp_d && m));
      chk($sformatf("R2 R10 data %s c=%0d", name, c), 32'(rd_data_o),
          exp_v ? 32'(bval(c - 1)) : 32'd0);
    end
  endtask

  task automatic t_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid", 32'(rd_valid_o), 0);
    chk("R1 drop", 32'(rd_drop_o), 0);
    chk("R1 data", 32'(rd_data_o), 0);
    chk("R1 oe", 32'(dq_oe_o), 0);
    rst_ni = 1;
    @(negedge clk); #1;
    chk("R1 valid after", 32'(rd_valid_o), 0);
    chk("R1 oe after", 32'(dq_oe_o), 0);
  endtask

  task automatic t_read_latencies();
    clear_stim(); s_rd[2] = 1; run_seq(2'd1, 2'd0, "R2_lat1_bl1");
    clear_stim(); s_rd[2] = 1; run_seq(2'd2, 2'd2, "R2_lat2_bl4");
    clear_stim(); s_rd[2] = 1; run_seq(2'd3, 2'd3, "R3_lat3_bl8");
    clear_stim(); s_rd[2] = 1; run_seq(2'd0, 2'd1, "R2_lat0_bl2");
  endtask

  task automatic t_read_mask();
    clear_stim(); s_rd[2] = 1; s_mask[4] = 1; s_mask[5] = 1; s_mask[9] = 1;
    run_seq(2'd3, 2'd3, "R6_mask_lat3");
    clear_stim(); s_rd[3] = 1; s_mask[2] = 1; s_mask[4] = 1;
    run_seq(2'd1, 2'd2, "R6_mask_lat1");
  endtask

  task automatic t_write();
    clear_stim(); s_wr[2] = 1; s_mask[3] = 1; s_mask[5] = 1;
    run_seq(2'd2, 2'd2, "R4_R5_write");
    clear_stim(); s_rd[2] = 1; s_wr[4] = 1;
    run_seq(2'd3, 2'd1, "R9_turnaround");
  endtask

  task automatic t_term();
    clear_stim(); s_rd[2] = 1; s_term[5] = 1; s_wr[10] = 1; s_term[10] = 1;
    run_seq(2'd3, 2'd3, "R7_term");
  endtask

  task automatic t_b2b();
    clear_stim(); s_rd[2] = 1; s_rd[3] = 1; s_wr[5] = 1; s_rd[5] = 1;
    s_wr[9] = 1; s_rd[10] = 1; s_wr[16] = 1;
    run_seq(2'd2, 2'd2, "R8_b2b");
  endtask

  initial begin
    t_reset();
    t_read_latencies();
    t_read_mask();
    t_write();
    t_term();
    t_b2b();
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule